// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Integer Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. Each instruction is one 32-bit word taken from an internal, word-addressed instruction store. The instruction is decoded in the same cycle, which selects two source registers from a 32-entry register file. A small ALU produces the result. A load or store then uses an internal data store. The result is written back on the next rising clock edge. The core supports wrapping add and subtract, AND, OR, signed set-less-than, the immediate forms of these with the correct choice of sign or zero extension, load-upper-immediate, and load word and store word.

The surrounding logic fills the instruction store through a simple write port, normally while reset is held. Once reset is released, the core runs from address 0. Debug outputs show the current program counter and the register-file or data-store write that the current instruction will perform at the next clock edge. An observer can therefore follow the whole architectural state at the ports.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, and for one further clock edge after it rises (the synchronous release stage), dbg_pc is 0 and dbg_rf_we and dbg_dm_we are low.
- R2: After reset release, dbg_pc advances by exactly 4 on every clock edge, whatever the instruction. The instruction shown is the store word at index dbg_pc[IAW+1:2].
- R3: Register-format instructions (bits 31:26 = 0) select the operation with bits 5:0. The codes are 32 add, 34 subtract, 36 AND, 37 OR and 42 signed set-less-than. The result goes to the register named by bits 15:11, and add and subtract wrap modulo 2^32. Set-less-than writes 1 when the first source (bits 25:21) is below the second source (bits 20:16) as signed numbers, and 0 otherwise.
- R4: Immediate instructions take the 16-bit constant in bits 15:0 and write the register named by bits 20:16. They are opcode 8 (add), 10 (signed set-less-than), 12 (AND) and 13 (OR). Opcodes 8 and 10 sign-extend the constant, and opcodes 12 and 13 zero-extend it.
- R5: Opcode 15 writes the 16-bit constant into bits 31:16 of the register named by bits 20:16 and clears bits 15:0.
- R6: The destination register is named by bits 15:11 in register format, and by bits 20:16 for immediate instructions and loads. dbg_rf_addr shows it.
- R7: Register 0 always reads as zero. An instruction that targets it performs no write, and dbg_rf_we stays low.
- R8: Load word (opcode 35) and store word (opcode 43) use the byte address base register (bits 25:21) plus the sign-extended constant. The data-store word is selected by address bits DAW+1:2. A store shows the address and the value of register bits 20:16 on dbg_dm_*, and a later load returns the stored word.
- R9: Any other opcode, and any other bits 5:0 code under opcode 0, writes neither a register nor the data store.
- R10: When load_we is high, load_data is written at the next clock edge into the instruction store word at load_addr, whether or not reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_we | input | 1 | Instruction store write enable |
| load_addr | input | IAW | Instruction store word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Byte address of the instruction being executed |
| dbg_rf_we | output | 1 | Register write happens at the next edge |
| dbg_rf_addr | output | 5 | Destination register of that write |
| dbg_rf_data | output | 32 | Value of that write |
| dbg_dm_we | output | 1 | Data store write happens at the next edge |
| dbg_dm_addr | output | 32 | Byte address of the load or store |
| dbg_dm_data | output | 32 | Value stored |

## Verification
The bench builds the core with IMEM_WORDS = 256 and DMEM_WORDS = 16. The full instruction store then runs exactly once. Random stores and loads through r0 and through a base register with negative offsets fall on only sixteen words, so a load often reads a word that a recent random store has overwritten. The small data store also makes the index-from-address-bits path, including negative-offset wraparound to a positive address, a regular event rather than a rare one.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rt;
    logic    use_imm;
    logic    sext;
    logic    mem_rd;
    logic    dm_we;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       illegal
);

  always_comb begin
    ctrl    = '{rf_we: 1'b0, dst_rt: 1'b1, use_imm: 1'b1, sext: 1'b1,
                mem_rd: 1'b0, dm_we: 1'b0, alu_op: ALU_ADD};
    illegal = 1'b0;
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rt  = 1'b0;
        ctrl.use_imm = 1'b0;
        ctrl.rf_we   = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: begin
            ctrl.rf_we = 1'b0;
            illegal    = 1'b1;
          end
        endcase
      end
      OPC_ADDI: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD; end
      OPC_SLTI: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SLT; end
      OPC_ANDI: begin ctrl.rf_we = 1'b1; ctrl.sext = 1'b0; ctrl.alu_op = ALU_AND; end
      OPC_ORI:  begin ctrl.rf_we = 1'b1; ctrl.sext = 1'b0; ctrl.alu_op = ALU_OR;  end
      OPC_LUI:  begin ctrl.rf_we = 1'b1; ctrl.sext = 1'b0; ctrl.alu_op = ALU_LUI; end
      OPC_LW:   begin ctrl.rf_we = 1'b1; ctrl.mem_rd = 1'b1; end
      OPC_SW:   ctrl.dm_we = 1'b1;
      default:  illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_LUI: y = {b[15:0], {(XLEN-16){1'b0}}};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  // Entry 0 has no storage: it is the constant zero.
  logic [WIDTH-1:0] regs_q [1:DEPTH-1];

  for (genvar i = 1; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(i))) regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 256,
  parameter int unsigned DMEM_WORDS = 64,
  parameter int unsigned IAW        = $clog2(IMEM_WORDS),
  parameter int unsigned DAW        = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_we,
  input  logic [IAW-1:0]  load_addr,
  input  logic [31:0]     load_data,
  output logic [31:0]     dbg_pc,
  output logic            dbg_rf_we,
  output logic [4:0]      dbg_rf_addr,
  output logic [31:0]     dbg_rf_data,
  output logic            dbg_dm_we,
  output logic [31:0]     dbg_dm_addr,
  output logic [31:0]     dbg_dm_data
);

  localparam int unsigned RAW = $clog2(NREG);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Program counter
  logic [XLEN-1:0] pc_q, pc_d;

  always_comb pc_d = pc_q + XLEN'(4);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  // Instruction store with preload port
  logic [31:0] imem_q [IMEM_WORDS];
  logic [31:0] instr;

  always_ff @(posedge clk) begin
    if (load_we) imem_q[load_addr] <= load_data;
  end
  assign instr = imem_q[pc_q[IAW+1:2]];

  // Decode
  ctrl_t ctrl;
  logic  illegal;

  sc_decode u_dec (
    .opcode  (instr[31:26]),
    .funct   (instr[5:0]),
    .ctrl    (ctrl),
    .illegal (illegal)
  );

  logic [RAW-1:0]  rs, rt, rd, dst;
  logic [XLEN-1:0] imm_ext, src_a, src_b, opnd_b, alu_y, wb_data, dm_rdata;
  logic            rf_we_eff, dm_we_eff;

  always_comb begin
    rs      = instr[25:21];
    rt      = instr[20:16];
    rd      = instr[15:11];
    dst     = ctrl.dst_rt ? rt : rd;
    imm_ext = ctrl.sext ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                        : {{(XLEN-16){1'b0}}, instr[15:0]};
    opnd_b  = ctrl.use_imm ? imm_ext : src_b;
  end

  sc_regfile #(.WIDTH(XLEN), .DEPTH(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we_eff),
    .waddr   (dst),
    .wdata   (wb_data),
    .raddr_a (rs),
    .raddr_b (rt),
    .rdata_a (src_a),
    .rdata_b (src_b)
  );

  sc_alu u_alu (
    .a  (src_a),
    .b  (opnd_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  // Data store: word index from the byte address
  logic [31:0] dmem_q [DMEM_WORDS];

  always_ff @(posedge clk) begin
    if (dm_we_eff) dmem_q[alu_y[DAW+1:2]] <= src_b;
  end
  assign dm_rdata = dmem_q[alu_y[DAW+1:2]];

  // Write-back: committed only once the reset release has settled
  always_comb begin
    wb_data   = ctrl.mem_rd ? dm_rdata : alu_y;
    rf_we_eff = rst_sync_n & ctrl.rf_we & (dst != '0);
    dm_we_eff = rst_sync_n & ctrl.dm_we;
  end

  assign dbg_pc      = pc_q;
  assign dbg_rf_we   = rf_we_eff;
  assign dbg_rf_addr = dst;
  assign dbg_rf_data = wb_data;
  assign dbg_dm_we   = dm_we_eff;
  assign dbg_dm_addr = alu_y;
  assign dbg_dm_data = src_b;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2], alu_y[1:0], alu_y[XLEN-1:DAW+2]};

  // Checks
  assert_reset_pc_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (dbg_pc == '0 && !dbg_rf_we && !dbg_dm_we));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (dbg_pc == $past(dbg_pc) + 32'd4));

  assert_lui_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.alu_op == ALU_LUI && dbg_rf_we) |-> (dbg_rf_data[15:0] == 16'h0));

  assert_no_r0_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_rf_we |-> (dbg_rf_addr != 5'd0));

  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dbg_rf_we && dbg_dm_we));

  assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (!dbg_rf_we && !dbg_dm_we));

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

  localparam int unsigned IW  = 256;
  localparam int unsigned DW  = 16;
  localparam int unsigned IAW = $clog2(IW);
  localparam int unsigned DAW = $clog2(DW);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           load_we;
  logic [IAW-1:0] load_addr;
  logic [31:0]    load_data;
  logic [31:0]    dbg_pc, dbg_rf_data, dbg_dm_addr, dbg_dm_data;
  logic [4:0]     dbg_rf_addr;
  logic           dbg_rf_we, dbg_dm_we;

  always #2 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
    .dbg_rf_addr(dbg_rf_addr), .dbg_rf_data(dbg_rf_data), .dbg_dm_we(dbg_dm_we),
    .dbg_dm_addr(dbg_dm_addr), .dbg_dm_data(dbg_dm_data)
  );

  int unsigned tests = 0;
  int unsigned fails = 0;
  bit          done  = 0;

  logic [31:0] prog [IW];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DW];
  logic [31:0] mpc;
  int          p;

  logic        e_rf_we, e_dm_we;
  logic [4:0]  e_rf_addr;
  logic [31:0] e_rf_data, e_dm_addr, e_dm_data;
  string       tag;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at pc %0h: actual %0h expected %0h", req, what, mpc, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    if (p < IW) prog[p] = w;
    p++;
  endtask

  // Independent reference: expected effects of one instruction.
  task automatic model(input logic [31:0] ins);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [31:0] a  = mreg[ins[25:21]];
    logic [31:0] b  = mreg[ins[20:16]];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx = {16'h0, ins[15:0]};
    bit          wr = 1'b1;
    e_rf_we = 0; e_dm_we = 0; e_rf_data = '0; e_dm_addr = '0; e_dm_data = '0;
    e_rf_addr = ins[20:16];
    tag = "R4";
    case (op)
      6'd0: begin
        e_rf_addr = ins[15:11];
        tag = "R3";
        case (fn)
          6'd32: e_rf_data = a + b;
          6'd34: e_rf_data = a - b;
          6'd36: e_rf_data = a & b;
          6'd37: e_rf_data = a | b;
          6'd42: e_rf_data = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin wr = 0; tag = "R9"; end
        endcase
      end
      6'd8:  e_rf_data = a + sx;
      6'd10: e_rf_data = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      6'd12: e_rf_data = a & zx;
      6'd13: e_rf_data = a | zx;
      6'd15: begin e_rf_data = {ins[15:0], 16'h0}; tag = "R5"; end
      6'd35: begin
        e_dm_addr = a + sx;
        e_rf_data = mdm[e_dm_addr[DAW+1:2]];
        tag = "R8";
      end
      6'd43: begin
        wr = 0; e_dm_we = 1; tag = "R8";
        e_dm_addr = a + sx; e_dm_data = b;
      end
      default: begin wr = 0; tag = "R9"; end
    endcase
    if (wr && e_rf_addr == 5'd0) begin wr = 0; tag = "R7"; end
    e_rf_we = wr;
  endtask

  task automatic gen_random();
    int k  = int'($urandom % 14);
    int rs = int'($urandom % 32);
    int rt = int'($urandom % 32);
    int rd = int'($urandom % 32);
    int im = int'($urandom % 65536);
    int ix = int'($urandom % DW);
    if (rt == 29) rt = 28;
    if (rd == 29) rd = 27;
    case (k)
      0: emit(enc_r(rs, rt, rd, 32));
      1: emit(enc_r(rs, rt, rd, 34));
      2: emit(enc_r(rs, rt, rd, 36));
      3: emit(enc_r(rs, rt, rd, 37));
      4: emit(enc_r(rs, rt, rd, 42));
      5: emit(enc_i(8,  rs, rt, im));
      6: emit(enc_i(10, rs, rt, im));
      7: emit(enc_i(12, rs, rt, im));
      8: emit(enc_i(13, rs, rt, im));
      9: emit(enc_i(15, rs, rt, im));
      10: emit(($urandom % 2 == 0) ? enc_i(35, 0, rt, 4*ix) : enc_i(35, 29, rt, 4*ix - 4*int'(DW)));
      11: emit(($urandom % 2 == 0) ? enc_i(43, 0, rt, 4*ix) : enc_i(43, 29, rt, 4*ix - 4*int'(DW)));
      12: emit(enc_i(2 + int'($urandom % 3), rs, rt, im));
      default: emit(enc_r(rs, rt, rd, 0));
    endcase
  endtask

  initial begin
    void'($urandom(32'd2718));
    p = 0;
    // Initialise registers and data store so every read is defined.
    for (int r = 1; r < 32; r++)
      emit(enc_i(13, 0, r, (r == 29) ? 4*int'(DW) : int'($urandom % 65536)));
    for (int w = 0; w < int'(DW); w++) emit(enc_i(43, 0, (w % 31) + 1, 4*w));
    // Directed corner cases
    emit(enc_i(15, 7, 1, 16'h7fff));        // R5 lui, rs ignored
    emit(enc_i(13, 1, 1, 16'hffff));        // R4 ori zero-extends
    emit(enc_i(8, 1, 2, 1));                // R4 addi wraps to 0x80000000
    emit(enc_r(1, 1, 3, 32));               // R3 add wraps
    emit(enc_r(0, 1, 4, 34));               // R3 sub from zero
    emit(enc_r(2, 1, 5, 42));               // R3 slt negative < positive
    emit(enc_r(1, 2, 6, 42));               // R3 slt positive > negative
    emit(enc_i(10, 1, 7, 16'hffff));        // R4 slti with -1
    emit(enc_i(12, 2, 8, 16'hffff));        // R4 andi zero-extends
    emit(enc_i(8, 0, 9, 16'hffff));         // R4 addi sign-extends
    emit(enc_r(1, 1, 0, 32));               // R7 write to r0
    emit(enc_r(0, 0, 10, 37));              // R7 r0 reads zero
    emit(enc_i(43, 29, 9, -4));             // R8 negative offset store
    emit(enc_i(35, 0, 11, 4*(int'(DW)-1))); // R8 load back
    emit(enc_i(63, 1, 12, 5));              // R9 unknown opcode
    emit(enc_r(1, 2, 13, 33));              // R9 unknown funct
    emit(enc_i(35, 0, 0, 0));               // R7 load to r0
    while (p < int'(IW)) gen_random();

    // R10: preload the store while reset is held
    rst_n = 1'b0; load_we = 1'b0; load_addr = '0; load_data = '0;
    for (int i = 0; i < int'(IW); i++) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = IAW'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0;
    mpc = '0;
    check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    check(!dbg_rf_we && !dbg_dm_we, "R1", "writes in reset", {dbg_rf_we, dbg_dm_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dbg_pc == 32'd0, "R1", "pc during release", dbg_pc, 32'd0);
    check(!dbg_rf_we && !dbg_dm_we, "R1", "writes during release", {dbg_rf_we, dbg_dm_we}, 32'd0);
    for (int r = 0; r < 32; r++) mreg[r] = '0;
    @(negedge clk);

    for (int n = 0; n < int'(IW); n++) begin
      model(prog[mpc[IAW+1:2]]);
      check(dbg_pc == mpc, "R2", "pc", dbg_pc, mpc);
      check(dbg_rf_we == e_rf_we, tag, "rf_we", 32'(dbg_rf_we), 32'(e_rf_we));
      if (e_rf_we) begin
        check(dbg_rf_addr == e_rf_addr, "R6", "rf_addr", 32'(dbg_rf_addr), 32'(e_rf_addr));
        check(dbg_rf_data == e_rf_data, tag, "rf_data", dbg_rf_data, e_rf_data);
      end
      check(dbg_dm_we == e_dm_we, tag, "dm_we", 32'(dbg_dm_we), 32'(e_dm_we));
      if (e_dm_we) begin
        check(dbg_dm_addr == e_dm_addr, "R8", "dm_addr", dbg_dm_addr, e_dm_addr);
        check(dbg_dm_data == e_dm_data, "R8", "dm_data", dbg_dm_data, e_dm_data);
      end
      if (e_rf_we) mreg[e_rf_addr] = e_rf_data;
      if (e_dm_we) mdm[e_dm_addr[DAW+1:2]] = e_dm_data;
      mpc = mpc + 32'd4;
      @(negedge clk);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule